// File: doc/BRIEF.md
# Snooping Invalidate Cache Controller

This block is the private cache of one processor in a small multiprocessor whose caches share a single arbitrated bus. It is a direct-mapped, write-back cache. Each line has a tag, a valid bit and a dirty bit, and these give three line states: Invalid, Shared-clean (valid, not dirty) and Modified (valid, dirty). Processor reads and writes that hit are served locally. A miss, a write-back of a dirty victim, or the first write to a clean line needs a bus transaction, and the controller gets the bus through a request/grant handshake.

While it works, the controller watches every transaction that other masters place on the bus. If another master announces a write to a line, the local copy is dropped, so the next local access to that line misses and refetches. If another master reads a line that this cache holds Modified, the controller drives the current line onto the intervention outputs in that same bus cycle, so the reader gets it in place of stale memory, and the local copy falls back to Shared-clean. The bus carries one transaction per cycle, so every cache sees all writes in one order.

A bus transaction moves one whole line (4 words of 32 bits with the defaults) in a single cycle. Read data arrives on `bus_rdata` in the granted cycle. Bus commands are encoded 1 = line read, 2 = write-back, 3 = invalidate.

Top module: `snoop_cache`

## Requirements
- R1: A processor read that misses issues one bus read (command 1) with the line address, and the line is then held Shared-clean, so a repeat read causes no bus traffic.
- R2: A read hit completes with no bus transaction and returns the addressed 32-bit word (word select is address bits [3:2]).
- R3: A write to a Shared-clean line issues exactly one invalidate (command 3) carrying only the line address (low 4 bits zero) and leaves the line Modified.
- R4: A write to a Modified line completes with no bus transaction.
- R5: A write miss first reads the line (command 1) and then invalidates it (command 3).
- R6: When another master's invalidate hits a held line, the line is dropped, and the next local access misses and issues a bus read.
- R7: When another master's read hits a Modified line, `snp_intervene` is asserted in that same cycle with the current line on `snp_data`, and the line becomes Shared-clean, so the next local write issues an invalidate again.
- R8: A snooped read of a clean or absent line does not assert `snp_intervene`, and no other snooped command ever asserts it.
- R9: Replacing a Modified line first writes it back (command 2) with the victim's address and latest data, and only then issues the refill read.
- R10: The bus outputs are valid only in a granted cycle. `bus_req` stays asserted while the grant is withheld, and no bus output is driven while in reset.
- R11: A processor request never completes in a cycle in which a snooped transaction is present.
- R12: Under any interleaving of local requests and other masters' reads and writes, every read returns, and every snooped read or write-back carries, the latest value written in bus order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address of the word |
| cpu_wdata | input | 32 | Write data |
| cpu_ready | output | 1 | Request completes in this cycle |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ready` |
| bus_req | output | 1 | Request for the shared bus |
| bus_gnt | input | 1 | Bus granted this cycle |
| bo_valid | output | 1 | Own transaction on the bus this cycle |
| bo_cmd | output | 2 | Own command: 1 read, 2 write-back, 3 invalidate |
| bo_addr | output | 32 | Own line address |
| bo_data | output | 128 | Line data for a write-back |
| bus_rdata | input | 128 | Line returned for an own read in the granted cycle |
| snp_valid | input | 1 | Another master's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same encoding |
| snp_addr | input | 32 | Snooped line address |
| snp_intervene | output | 1 | This cache supplies the snooped read's line |
| snp_data | output | 128 | Line supplied on intervention |

## Verification
The assertions take for granted that the arbiter never grants this cache in a cycle that carries another master's transaction, that the processor holds its request stable until it completes, and that other masters follow the protocol: a foreign write to a line is always preceded by a foreign read of it, so a foreign invalidate never meets a Modified local line. The bench acts as arbiter, memory and every other master at once. It grants only in cycles where it injects no snoop, and it injects foreign writes only as a read followed at once by an invalidate. The random phase uses few tags and indices, so that snoops land on lines that are being upgraded, written back or refilled.

// File: rtl/snoop_cache.sv
`timescale 1ns/1ps
module snoop_cache #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int LINES = 16,
  parameter int WORDS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cpu_req,
  input  logic                cpu_we,
  input  logic [AW-1:0]       cpu_addr,
  input  logic [DW-1:0]       cpu_wdata,
  output logic                cpu_ready,
  output logic [DW-1:0]       cpu_rdata,
  output logic                bus_req,
  input  logic                bus_gnt,
  output logic                bo_valid,
  output logic [1:0]          bo_cmd,
  output logic [AW-1:0]       bo_addr,
  output logic [DW*WORDS-1:0] bo_data,
  input  logic [DW*WORDS-1:0] bus_rdata,
  input  logic                snp_valid,
  input  logic [1:0]          snp_cmd,
  input  logic [AW-1:0]       snp_addr,
  output logic                snp_intervene,
  output logic [DW*WORDS-1:0] snp_data
);
  localparam int BO = $clog2(DW/8);
  localparam int WW = $clog2(WORDS);
  localparam int IW = $clog2(LINES);
  localparam int OW = BO + WW;
  localparam int TW = AW - IW - OW;
  localparam int LW = DW * WORDS;
  localparam logic [1:0] CMD_RD = 2'd1, CMD_WB = 2'd2, CMD_INV = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_UPG, S_WB, S_FILL} st_t;
  st_t st, st_n;

  logic [LINES-1:0] vld, dty;
  logic [TW-1:0]    tagm [LINES];
  logic [LW-1:0]    dat  [LINES];

  logic [IW-1:0] ci, si;
  logic [TW-1:0] ct, stg;
  logic [WW-1:0] cw;
  logic          hit, shit, victim_dirty, ready_idle, upg_go;
  logic          unused_bits;

  assign ci  = cpu_addr[OW +: IW];
  assign ct  = cpu_addr[AW-1 -: TW];
  assign cw  = cpu_addr[BO +: WW];
  assign si  = snp_addr[OW +: IW];
  assign stg = snp_addr[AW-1 -: TW];
  assign unused_bits = ^{cpu_addr[BO-1:0], snp_addr[OW-1:0]};

  assign hit          = vld[ci] && (tagm[ci] == ct);
  assign victim_dirty = vld[ci] && dty[ci];
  assign shit         = snp_valid && vld[si] && (tagm[si] == stg);

  assign snp_intervene = shit && dty[si] && (snp_cmd == CMD_RD);
  assign snp_data      = dat[si];
  assign cpu_rdata     = dat[ci][cw*DW +: DW];

  assign ready_idle = (st == S_IDLE) && cpu_req && !snp_valid && hit && (!cpu_we || dty[ci]);
  assign upg_go     = (st == S_UPG) && hit && bus_gnt && !snp_valid;
  assign cpu_ready  = ready_idle || upg_go;

  assign bus_req  = ((st == S_UPG) && hit) || ((st == S_WB) && victim_dirty) || (st == S_FILL);
  assign bo_valid = bus_req && bus_gnt;
  assign bo_cmd   = (st == S_UPG) ? CMD_INV : (st == S_WB) ? CMD_WB : CMD_RD;
  assign bo_addr  = (st == S_WB) ? {tagm[ci], ci, {OW{1'b0}}} : {ct, ci, {OW{1'b0}}};
  assign bo_data  = (st == S_WB) ? dat[ci] : '0;

  always_comb begin
    st_n = st;
    case (st)
      S_IDLE: if (cpu_req && !snp_valid) begin
        if (!hit)                    st_n = victim_dirty ? S_WB : S_FILL;
        else if (cpu_we && !dty[ci]) st_n = S_UPG;
      end
      S_UPG:  if (!hit || upg_go)           st_n = S_IDLE;
      S_WB:   if (!victim_dirty || bus_gnt) st_n = S_FILL;
      S_FILL: if (bus_gnt)                  st_n = S_IDLE;
      default:                              st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      vld <= '0;
      dty <= '0;
    end else begin
      st <= st_n;
      if (shit && snp_cmd == CMD_INV) begin
        vld[si] <= 1'b0;
        dty[si] <= 1'b0;
      end
      if (snp_intervene) dty[si] <= 1'b0;
      if (st == S_FILL && bo_valid) begin
        vld[ci] <= 1'b1;
        dty[ci] <= 1'b0;
      end
      if (st == S_WB && bo_valid) dty[ci] <= 1'b0;
      if (cpu_ready && cpu_we)    dty[ci] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_FILL && bo_valid) begin
      tagm[ci] <= ct;
      dat[ci]  <= bus_rdata;
    end
    if (cpu_ready && cpu_we) dat[ci][cw*DW +: DW] <= cpu_wdata;
  end

  a_r10_bus_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_gnt && snp_valid));
  a_r1_fill_shared: assert property (@(posedge clk) disable iff (!rst_n)
    (bo_valid && bo_cmd == CMD_RD) |=> (vld[$past(ci)] && !dty[$past(ci)]));
  a_r3_upgrade_modified: assert property (@(posedge clk) disable iff (!rst_n)
    (bo_valid && bo_cmd == CMD_INV) |=> (vld[$past(ci)] && dty[$past(ci)]));
  a_r6_snoop_inv_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (shit && snp_cmd == CMD_INV) |=> !vld[$past(si)]);
  a_r7_intervene_cleans: assert property (@(posedge clk) disable iff (!rst_n)
    snp_intervene |=> !dty[$past(si)]);
  a_r9_no_dirty_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    (bo_valid && bo_cmd == CMD_RD) |-> !victim_dirty);
endmodule

// File: tb/snoop_cache_test.sv
`timescale 1ns/1ps
module snoop_cache_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst_n, cpu_req, cpu_we, cpu_ready, bus_req, bus_gnt, bo_valid;
  logic         snp_valid, snp_intervene;
  logic [31:0]  cpu_addr, cpu_wdata, cpu_rdata, bo_addr, snp_addr;
  logic [1:0]   bo_cmd, snp_cmd;
  logic [127:0] bo_data, bus_rdata, snp_data;

  logic [127:0] mem   [64];
  logic [31:0]  truth [64][4];
  assign bus_rdata = mem[bo_addr[9:4]];

  snoop_cache uut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bo_valid(bo_valid), .bo_cmd(bo_cmd),
    .bo_addr(bo_addr), .bo_data(bo_data), .bus_rdata(bus_rdata),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .snp_intervene(snp_intervene), .snp_data(snp_data)
  );

  int checks = 0, fails = 0;
  bit sp_valid = 0, rand_inj = 0, inv_pend = 0, done = 0, last_interv = 0;
  logic [1:0]  sp_cmd;
  logic [31:0] sp_addr, inv_addr, got, last_inv_addr;
  logic [7:0]  seq;
  int withhold = 0, nticks = 0;

  task automatic chk(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [127:0] line_of(int l);
    return {truth[l][3], truth[l][2], truth[l][1], truth[l][0]};
  endfunction

  function automatic logic [31:0] mk_addr(int tg, int idx, int w);
    return {22'd0, tg[1:0], idx[3:0], w[1:0], 2'b00};
  endfunction

  task automatic tick();
    bit sn;
    logic [1:0] c;
    logic [31:0] a;
    int l, w;
    @(negedge clk);
    sn = 0; c = 0; a = 0;
    if (inv_pend) begin
      sn = 1; c = 2'd3; a = inv_addr; inv_pend = 0;
    end else if (sp_valid) begin
      sn = 1; c = sp_cmd; a = sp_addr; sp_valid = 0;
    end else if (rand_inj && bus_req && ($urandom % 3 == 0)) begin
      sn = 1; c = 2'd1; a = mk_addr($urandom % 4, $urandom % 4, 0);
      if ($urandom % 2 == 1) begin inv_pend = 1; inv_addr = a; end
    end
    snp_valid = sn; snp_cmd = c; snp_addr = a;
    if (!sn && bus_req && withhold > 0) begin
      bus_gnt = 0; withhold--;
    end else bus_gnt = bus_req && !sn;
    #5;
    l = int'(a[9:4]);
    if (sn && c == 2'd1) begin
      last_interv = snp_intervene;
      chk((snp_intervene ? snp_data : mem[l]) == line_of(l), "R12", "snooped read data",
          snp_intervene ? snp_data : mem[l], line_of(l));
      if (snp_intervene) mem[l] = snp_data;
    end else if (snp_intervene) chk(0, "R8", "intervene without snooped read", 1, 0);
    if (sn && c == 2'd3) begin
      w = $urandom % 4;
      truth[l][w] = $urandom;
      mem[l] = line_of(l);
    end
    if (bo_valid) begin
      if (!bus_gnt) chk(0, "R10", "bus output without grant", 0, 1);
      seq = {seq[5:0], bo_cmd};
      if (bo_cmd == 2'd2) begin
        chk(bo_data == line_of(int'(bo_addr[9:4])), "R9", "write-back data", bo_data,
            line_of(int'(bo_addr[9:4])));
        mem[bo_addr[9:4]] = bo_data;
      end
      if (bo_cmd == 2'd3) last_inv_addr = bo_addr;
    end
    if (cpu_ready && cpu_req) begin
      if (snp_valid) chk(0, "R11", "completion during snoop", 1, 0);
      if (cpu_we) truth[cpu_addr[9:4]][cpu_addr[3:2]] = cpu_wdata;
      else got = cpu_rdata;
      done = 1;
    end
    nticks++;
    @(posedge clk); #1;
    snp_valid = 0; bus_gnt = 0; snp_cmd = 0; snp_addr = 0;
    if (done) cpu_req = 0;
  endtask

  task automatic cpu_op(bit we, logic [31:0] a, logic [31:0] d);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    done = 0; seq = 0; nticks = 0;
    while (!done && nticks < 80) tick();
    if (!done) chk(0, "R12", "request never completed", nticks, 0);
  endtask

  task automatic snoop_only(logic [1:0] c, logic [31:0] a);
    sp_valid = 1; sp_cmd = c; sp_addr = a;
    tick();
  endtask

  task automatic read_chk(logic [31:0] a, string req);
    cpu_op(0, a, 0);
    chk(got == truth[a[9:4]][a[3:2]], req, "read data", got, truth[a[9:4]][a[3:2]]);
  endtask

  initial begin
    #(20 * 200000);
    chk(0, "WDOG", "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int l = 0; l < 64; l++) begin
      for (int w = 0; w < 4; w++) truth[l][w] = $urandom;
      mem[l] = line_of(l);
    end
    rst_n = 0; cpu_req = 0; cpu_we = 0; cpu_addr = 0; cpu_wdata = 0;
    bus_gnt = 0; snp_valid = 0; snp_cmd = 0; snp_addr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!bus_req && !bo_valid, "R10", "bus idle in reset", {bus_req, bo_valid}, 0);
    chk(!cpu_ready && !snp_intervene, "R10", "no completion or intervention in reset",
        {cpu_ready, snp_intervene}, 0);
    @(posedge clk); #1 rst_n = 1;

    read_chk(mk_addr(0, 1, 2), "R1");
    chk(seq == 8'h01, "R1", "read miss bus sequence", seq, 8'h01);
    read_chk(mk_addr(0, 1, 1), "R2");
    chk(seq == 8'h00, "R2", "read hit bus sequence", seq, 0);

    cpu_op(1, mk_addr(0, 1, 1), 32'hA5A5_0001);
    chk(seq == 8'h03, "R3", "shared write bus sequence", seq, 8'h03);
    chk(last_inv_addr == mk_addr(0, 1, 0), "R3", "invalidate address", last_inv_addr, mk_addr(0, 1, 0));
    cpu_op(1, mk_addr(0, 1, 3), 32'h5A5A_0003);
    chk(seq == 8'h00, "R4", "modified write bus sequence", seq, 0);
    read_chk(mk_addr(0, 1, 1), "R4");
    chk(seq == 8'h00, "R4", "read after local writes stays local", seq, 0);

    snoop_only(2'd1, mk_addr(0, 1, 0));
    chk(last_interv == 1, "R7", "intervention on modified line", last_interv, 1);
    cpu_op(1, mk_addr(0, 1, 0), 32'h1234_5678);
    chk(seq == 8'h03, "R7", "write after intervention invalidates again", seq, 8'h03);

    snoop_only(2'd1, mk_addr(0, 1, 0));
    snoop_only(2'd3, mk_addr(0, 1, 0));
    read_chk(mk_addr(0, 1, 1), "R6");
    chk(seq == 8'h01, "R6", "access after foreign invalidate misses", seq, 8'h01);

    snoop_only(2'd1, mk_addr(0, 1, 0));
    chk(last_interv == 0, "R8", "no intervention on clean line", last_interv, 0);

    cpu_op(1, mk_addr(1, 2, 2), 32'hCAFE_0002);
    chk(seq == 8'h07, "R5", "write miss bus sequence", seq, 8'h07);
    read_chk(mk_addr(2, 2, 0), "R9");
    chk(seq == 8'h09, "R9", "write-back before refill", seq, 8'h09);
    cpu_op(1, mk_addr(2, 2, 1), 32'hBEEF_0001);
    chk(seq == 8'h03, "R3", "upgrade of refilled line", seq, 8'h03);
    cpu_op(1, mk_addr(3, 2, 0), 32'hD00D_0000);
    chk(seq == 8'h27, "R9", "write miss over modified victim", seq, 8'h27);
    read_chk(mk_addr(2, 2, 1), "R12");

    sp_valid = 1; sp_cmd = 2'd1; sp_addr = mk_addr(3, 9, 0);
    read_chk(mk_addr(0, 1, 1), "R11");
    chk(nticks == 2 && seq == 8'h00, "R11", "hit held off by snoop", nticks, 2);

    withhold = 3;
    read_chk(mk_addr(0, 5, 3), "R10");
    chk(nticks == 6 && seq == 8'h01, "R10", "request held until grant", nticks, 6);

    rand_inj = 1;
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a;
      a = mk_addr($urandom % 4, $urandom % 4, $urandom % 4);
      if ($urandom % 2 == 1) cpu_op(1, a, $urandom);
      else read_chk(a, "R12");
      if ($urandom % 8 == 0) snoop_only(2'd1, mk_addr($urandom % 4, $urandom % 4, 0));
    end
    rand_inj = 0;
    tick();
    for (int t = 0; t < 4; t++)
      for (int x = 0; x < 4; x++) read_chk(mk_addr(t, x, x), "R12");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule